// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns one parallel character into an asynchronous serial frame on a single output line. A character is offered with a one-cycle load strobe. The frame shape is set at run time by a group of format inputs: the character length (5 to 8 bits), whether a parity bit is added, odd or even parity, a fixed ("stick") parity value, and one, one-and-a-half or two stop bits. The format is captured together with the character, so a frame keeps its shape even if the inputs change while it is being sent.

Bit timing comes from an external oversampling strobe that pulses sixteen times per bit period. The framer counts these pulses and moves through start, data, optional parity and stop phases. A busy flag is high from the cycle after an accepted load until the last stop bit has run out. A separate break input pulls the line low while the framer keeps sequencing underneath, so frame timing does not change while break is applied.

Top module: `uart_tx_framer`

## Requirements
- R1: `len_sel` picks the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits go out least significant first, and bits above the selected length are not sent.
- R2: With `par_en` high, one parity bit follows the last data bit. With `par_even` high, the data bits plus the parity bit hold an even number of ones. With `par_even` low, they hold an odd number.
- R3: With `par_en` and `par_stick` both high, the parity bit is a constant: 1 when `par_even` is low and 0 when `par_even` is high.
- R4: With `par_en` low, no parity bit is sent, whatever `par_even` and `par_stick` are set to.
- R5: With `stop_sel` low, the stop phase lasts 16 ticks. With `stop_sel` high, it lasts 24 ticks for 5-bit characters and 32 ticks for the other lengths. Start, data and parity bits last 16 ticks each.
- R6: While `brk` is high, `txd` is held low one clock later. The frame's duration and the `busy` timing do not change.
- R7: After reset, `txd` is 1, `busy` is 0 and the captured format is 5 bits, one stop bit and no parity.
- R8: The line idles at 1. Every frame begins with one start bit at 0, and the stop bits are at 1.
- R9: A load while `busy` is high is ignored. It neither changes the frame in progress nor queues a new one.
- R10: A load while idle raises `busy` on the next cycle. The format and data are captured at that moment, so later changes to the inputs do not affect the frame. `busy` falls on the tick that ends the last stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_16x | input | 1 | Oversampling strobe, one-cycle pulse, 16 per bit |
| load | input | 1 | Offer a character (accepted only when idle) |
| load_data | input | 8 | Character, LSB sent first |
| len_sel | input | 2 | Character length select |
| par_en | input | 1 | Add a parity bit |
| par_even | input | 1 | Even (1) or odd (0) parity |
| par_stick | input | 1 | Fixed parity value |
| stop_sel | input | 1 | Longer stop phase |
| brk | input | 1 | Force the line low |
| txd | output | 1 | Serial output, registered |
| busy | output | 1 | Frame in progress |

## Verification
The bench samples each bit at its centre and also measures the whole frame in ticks. This catches a design that sends the wrong number of data bits, misses the 24-tick stop phase for 5-bit characters, or leaves the upper data bits unmasked. It goes after the parity variants: inverted even/odd sense, a stick value of the wrong polarity, and a parity bit that appears when parity is off. A design with either fault sends a wrong bit or a frame of the wrong length. It loads during a frame and changes the format inputs mid-frame. A design that accepts the second load, or reads the format live, sends an extra frame or a frame of the wrong shape. It also sends a frame under break. A design that stalls the sequencer, or does not force the line, shows a changed duration or a 1 bit on the line.

// File: rtl/uart_tx_pkg.sv
// Shared types and constants for the UART transmit framer.
// Assumes characters of at most 8 bits and a 2-bit length select.
package uart_tx_pkg;
    localparam int CHAR_MAX = 8;
    localparam int IDX_W    = $clog2(CHAR_MAX);

    // Frame phases, in the order they are sent.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_t;

    // Format captured with each character.
    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
        logic       stop_sel;
    } fmt_t;
endpackage

// File: rtl/uart_tx_capture.sv
// Captures the character and its format when a load is accepted, masks
// the data to the selected length and derives the parity bit.
// Assumes 'take' is asserted only when the framer is idle.
module uart_tx_capture
    import uart_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic [CHAR_MAX-1:0] din,
    input  fmt_t                fmt_in,
    output fmt_t                fmt_q,
    output logic [CHAR_MAX-1:0] data_q,
    output logic                par_bit
);
    logic [CHAR_MAX-1:0] mask;
    logic                ones_odd;

    // Keep the low 5 + len_sel bits of the offered character.
    always_comb begin
        for (int i = 0; i < CHAR_MAX; i++) begin
            mask[i] = (i < 5 + int'(fmt_in.len_sel));
        end
    end

    // Hold the character and its format for the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q  <= '0;
            data_q <= '0;
        end else if (take) begin
            fmt_q  <= fmt_in;
            data_q <= din & mask;
        end
    end

    // Parity bit: stick value or computed even/odd parity.
    always_comb begin
        ones_odd = ^data_q;
        if (fmt_q.par_stick) begin
            par_bit = ~fmt_q.par_even;
        end else if (fmt_q.par_even) begin
            par_bit = ones_odd;
        end else begin
            par_bit = ~ones_odd;
        end
    end
endmodule

// File: rtl/uart_tx_seq.sv
// Frame sequencer: counts oversampling ticks within each bit and walks
// through start, data, parity and stop phases.
// Assumes the format inputs are stable (captured) while not idle.
module uart_tx_seq
    import uart_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             take,
    input  fmt_t             fmt,
    output phase_t           phase,
    output logic [IDX_W-1:0] bit_idx
);
    localparam int CNT_W = $clog2(2 * OVS);
    localparam int LEN_W = CNT_W + 1;
    localparam logic [LEN_W-1:0] BIT_TICKS  = LEN_W'(OVS);
    localparam logic [LEN_W-1:0] HALF_TICKS = LEN_W'(OVS / 2);

    logic [CNT_W-1:0] tcnt;
    logic [LEN_W-1:0] bit_len;
    logic [IDX_W-1:0] last_idx;
    logic             bit_end;

    // Length of the current bit in ticks; the stop phase may be stretched.
    always_comb begin
        if (phase == PH_STOP && fmt.stop_sel) begin
            bit_len = (fmt.len_sel == 2'd0) ? BIT_TICKS + HALF_TICKS
                                            : BIT_TICKS + BIT_TICKS;
        end else begin
            bit_len = BIT_TICKS;
        end
        last_idx = IDX_W'(4 + int'(fmt.len_sel));
        bit_end  = tick && ({1'b0, tcnt} == bit_len - 1'b1);
    end

    // Phase, bit index and tick counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            tcnt    <= '0;
            bit_idx <= '0;
        end else if (phase == PH_IDLE) begin
            tcnt    <= '0;
            bit_idx <= '0;
            if (take) begin
                phase <= PH_START;
            end
        end else if (tick) begin
            if (!bit_end) begin
                tcnt <= tcnt + 1'b1;
            end else begin
                tcnt <= '0;
                unique case (phase)
                    PH_START: begin
                        phase   <= PH_DATA;
                        bit_idx <= '0;
                    end
                    PH_DATA: begin
                        if (bit_idx == last_idx) begin
                            phase <= fmt.par_en ? PH_PAR : PH_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    PH_PAR:  phase <= PH_STOP;
                    PH_STOP: phase <= PH_IDLE;
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_tx_line.sv
// Output stage: chooses the line level for the current phase and applies
// the break override. Registered so the pin is free of glitches.
// Assumes bit_idx is valid whenever the phase is PH_DATA.
module uart_tx_line
    import uart_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  phase_t              phase,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic [CHAR_MAX-1:0] data,
    input  logic                par_bit,
    input  logic                brk,
    output logic                txd
);
    logic level;

    // Line level for the phase in progress.
    always_comb begin
        unique case (phase)
            PH_START: level = 1'b0;
            PH_DATA:  level = data[bit_idx];
            PH_PAR:   level = par_bit;
            default:  level = 1'b1;
        endcase
    end

    // Register the pin; break wins over the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd <= 1'b1;
        end else begin
            txd <= level & ~brk;
        end
    end
endmodule

// File: rtl/uart_tx_framer.sv
// Top of the UART transmit framer. A load accepted while idle captures the
// character and its format and starts a frame. Bit timing follows an
// external strobe of OVS pulses per bit. Break forces only the pin.
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_16x,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    input  logic       stop_sel,
    input  logic       brk,
    output logic       txd,
    output logic       busy
);
    phase_t              phase;
    logic [IDX_W-1:0]    bit_idx;
    fmt_t                fmt_in, fmt_q;
    logic [CHAR_MAX-1:0] data_q;
    logic                par_bit;
    logic                take;

    // Gather the format inputs and qualify the load with idle.
    always_comb begin
        fmt_in.len_sel   = len_sel;
        fmt_in.par_en    = par_en;
        fmt_in.par_even  = par_even;
        fmt_in.par_stick = par_stick;
        fmt_in.stop_sel  = stop_sel;
        take             = load && (phase == PH_IDLE);
        busy             = (phase != PH_IDLE);
    end

    uart_tx_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .din     (load_data),
        .fmt_in  (fmt_in),
        .fmt_q   (fmt_q),
        .data_q  (data_q),
        .par_bit (par_bit)
    );

    uart_tx_seq #(.OVS(OVS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_16x),
        .take    (take),
        .fmt     (fmt_q),
        .phase   (phase),
        .bit_idx (bit_idx)
    );

    uart_tx_line u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .bit_idx (bit_idx),
        .data    (data_q),
        .par_bit (par_bit),
        .brk     (brk),
        .txd     (txd)
    );
endmodule

// File: rtl/uart_tx_framer_chk.sv
// Protocol checks on the framer's ports, bound to every instance.
module uart_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_16x,
    input logic load,
    input logic brk,
    input logic txd,
    input logic busy
);
    // Frame starts with a low start bit one cycle after busy rises.
    p_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> !txd);

    // Idle line with no break stays high.
    p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !busy && !$past(busy) && !$past(brk)) |-> txd);

    // Break pulls the pin low on the next cycle.
    p_break_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(brk)) |-> !txd);

    // A load while idle is accepted.
    p_load_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> busy);

    // A frame only ends on a tick; a load while busy never ends it.
    p_busy_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick_16x) |=> busy);
endmodule

bind uart_tx_framer uart_tx_framer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_16x (tick_16x),
    .load     (load),
    .brk      (brk),
    .txd      (txd),
    .busy     (busy)
);

// File: tb/uart_tx_framer_test.sv
module uart_tx_framer_test;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 3;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        logic [15:0] bits;
        int          nbits;
        int          total;
        string       tag;
    } frame_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16x = 1'b0;
    logic       load = 1'b0;
    logic [7:0] load_data = '0;
    logic [1:0] len_sel = '0;
    logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0, stop_sel = 1'b0;
    logic       brk = 1'b0;
    logic       txd, busy;

    int     checks = 0;
    int     fails  = 0;
    int     div    = 0;
    int     cycles = 0;
    frame_t expq[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_tx_framer uut (
        .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .load(load),
        .load_data(load_data), .len_sel(len_sel), .par_en(par_en),
        .par_even(par_even), .par_stick(par_stick), .stop_sel(stop_sel),
        .brk(brk), .txd(txd), .busy(busy)
    );

    // Tick generator: one pulse every TDIV clocks.
    always @(negedge clk) begin
        if (!rst_n) begin
            div      <= 0;
            tick_16x <= 1'b0;
        end else begin
            div      <= (div == TDIV - 1) ? 0 : div + 1;
            tick_16x <= (div == TDIV - 1);
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    // Monitor: pops the expected frame at busy rise, samples bit centres.
    bit          active = 0;
    int          ticks, idx;
    logic [15:0] got;
    frame_t      cur;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!active && busy) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R9", "unexpected frame", 1, 0);
                    cur.nbits = 0; cur.total = 0; cur.tag = "R9"; cur.bits = '0;
                end else begin
                    cur = expq.pop_front();
                end
                active = 1; ticks = 0; idx = 0; got = '0;
            end else if (active) begin
                if (tick_16x) begin
                    ticks++;
                    if (idx < cur.nbits && ticks == 8 + 16 * idx) begin
                        got[idx] = txd;
                        idx++;
                    end
                end
                if (!busy) begin
                    active = 0;
                    if (cur.nbits != 0) begin
                        check(got == cur.bits, cur.tag, "bit pattern", got, cur.bits);
                        check(ticks == cur.total, cur.tag, "frame ticks", ticks, cur.total);
                    end
                end
            end
        end
    end

    // Driver: offers one character and pushes the expected frame.
    task automatic send(input logic [7:0] d, input logic [1:0] ls,
                        input logic pe, input logic ev, input logic st,
                        input logic sb, input logic bk, input string tag);
        frame_t f;
        int     n, k, ones;
        logic   pbit;
        while (busy) @(negedge clk);
        n = 5 + int'(ls);
        f.bits = '0; k = 0; ones = 0;
        f.bits[k++] = 1'b0;                     // R8 start bit
        for (int i = 0; i < n; i++) begin       // R1 LSB first
            f.bits[k++] = d[i];
            ones += d[i];
        end
        if (pe) begin                           // R2, R3
            if (st) pbit = ~ev;
            else pbit = ev ? ones[0] : ~ones[0];
            f.bits[k++] = pbit;
        end
        f.bits[k++] = 1'b1;                     // stop bit
        if (bk) f.bits = '0;                    // R6
        f.nbits = k;
        f.total = 16 * (k - 1) + (!sb ? 16 : (ls == 2'd0 ? 24 : 32)); // R5
        f.tag = tag;
        expq.push_back(f);
        load_data = d; len_sel = ls; par_en = pe; par_even = ev;
        par_stick = st; stop_sel = sb; brk = bk; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (busy || active) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(txd == 1'b1, "R7", "txd in reset", txd, 1);
        check(busy == 1'b0, "R7", "busy in reset", busy, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(txd == 1'b1, "R7", "txd after reset", txd, 1);
        check(busy == 1'b0, "R7", "busy after reset", busy, 0);

        send(8'hA5, 2'd3, 0, 0, 0, 0, 0, "R1"); drain();
        send(8'hFD, 2'd0, 0, 0, 0, 0, 0, "R1"); drain();
        send(8'hD6, 2'd1, 0, 0, 0, 0, 0, "R1"); drain();
        send(8'h4B, 2'd2, 0, 0, 0, 0, 0, "R1"); drain();
        check(txd == 1'b1, "R8", "idle level", txd, 1);
        send(8'h35, 2'd2, 1, 1, 0, 0, 0, "R2"); drain();
        send(8'hC3, 2'd3, 1, 0, 0, 0, 0, "R2"); drain();
        send(8'h07, 2'd0, 1, 1, 0, 0, 0, "R2"); drain();
        send(8'hFF, 2'd3, 1, 0, 1, 0, 0, "R3"); drain();
        send(8'h01, 2'd3, 1, 1, 1, 0, 0, "R3"); drain();
        send(8'h5A, 2'd3, 0, 1, 1, 0, 0, "R4"); drain();
        send(8'h13, 2'd0, 0, 0, 0, 1, 0, "R5"); drain();
        send(8'h9C, 2'd3, 1, 1, 0, 1, 0, "R5"); drain();
        send(8'h2E, 2'd1, 0, 0, 0, 1, 0, "R5"); drain();
        send(8'h3C, 2'd3, 1, 0, 0, 0, 1, "R6"); drain();
        brk = 1'b0;
        repeat (2) @(negedge clk);
        check(txd == 1'b1, "R6", "line after break release", txd, 1);

        // R9/R10: load and format changes during a frame are ignored.
        send(8'h69, 2'd2, 1, 0, 0, 0, 0, "R10");
        repeat (40) @(negedge clk);
        load_data = 8'h00; len_sel = 2'd0; par_en = 0; stop_sel = 1; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (30) @(negedge clk);
        par_even = 1; par_stick = 1; len_sel = 2'd3;
        drain();
        repeat (200) @(negedge clk);
        check(busy == 1'b0, "R9", "no extra frame after ignored load", busy, 0);
        check(expq.size() == 0, "R9", "queue drained", expq.size(), 0);

        finish_run();
    end
endmodule